// File: doc/BRIEF.md
# Threshold-Stepped Receiver Gain Controller

The block moves a receiver front end along a fixed ladder of six combined amplifier, mixer and filter gain settings. Each cycle it compares an unsigned 8-bit signal-strength sample with two host thresholds. A sample above the upper threshold lowers the gain by one rung. A sample below the lower threshold raises it by one rung. After every gain change a dwell timer has to run out before the thresholds can act again. The dwell length comes from a host divide value that counts fractional ticks, so the default value 0x28 gives exactly 25 µs with a 50 MHz clock.

A two-bit lock selector picks one of four policies. In free running the controller tracks the thresholds. In manual the host sets the rung. In hold the gain is frozen. In preamble lock the controller tracks until the first preamble-detect pulse and then freezes. A host mode byte carries a hold override and the manual rung index. The current gain code is a registered output that can be read at any time.

Top module: `rx_gain_stepper`

## Requirements
- R1: Reset sets the gain to the top rung (code 0x16) and restarts the dwell timer. With divide d, the first automatic step comes max(1, ceil(d·125/4)) cycles after the last reset edge.
- R2: Rung index 0 to 5 maps to gain_code 0x00, 0x01, 0x02, 0x0A, 0x12, 0x16, from lowest to highest gain. gain_code is registered, always holds one of these six values, and updates on the clock edge where the decision is made.
- R3: When the dwell has expired and rssi > thr_high (unsigned), the gain drops exactly one rung. rssi equal to thr_high causes no step.
- R4: When the dwell has expired and rssi < thr_low, the gain rises exactly one rung. A sample inside [thr_low, thr_high] causes no step.
- R5: Automatic steps saturate at code 0x00 and at code 0x16 and never wrap. An automatic change is always a single rung.
- R6: Every gain change restarts the dwell. Automatic changes are spaced max(1, ceil(dwell_div·125/4)) cycles apart, which is 1250 cycles (25 µs at 50 MHz) for dwell_div 0x28. With dwell_div 0 a step can occur on every cycle.
- R7: lock_sel 0 tracks the thresholds freely. lock_sel 2 keeps the gain at its current rung whatever rssi does.
- R8: With lock_sel 1, host_mode[2:0] selects the rung index on the next edge. Values above 5 clamp to rung 5. The thresholds are ignored.
- R9: host_mode bit 6 set (for example 0x40) freezes the gain under every lock_sel, manual included. Clearing it (0x00) returns control to lock_sel.
- R10: With lock_sel 3 the gain freezes starting in the cycle in which preamble_det is high. It stays frozen until rx_en goes low or reset.
- R11: While rx_en is low no automatic step occurs, and a preamble lock is released. When rx_en returns high, tracking resumes on the next edge.
- R12: If a sample is both above thr_high and below thr_low, the step down wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive state active |
| rssi | input | 8 | Unsigned signal-strength sample |
| preamble_det | input | 1 | Preamble detected strobe |
| lock_sel | input | 2 | Lock policy: 0 free, 1 manual, 2 hold, 3 preamble lock |
| host_mode | input | 8 | Bit 6 host hold, bits 2:0 manual rung index |
| thr_high | input | 8 | Upper RSSI threshold |
| thr_low | input | 8 | Lower RSSI threshold |
| dwell_div | input | 8 | Dwell length in fractional ticks |
| gain_code | output | 8 | Current gain status code |

## Verification
A corrupted rung index or a broken code decode puts a value outside the six legal codes on gain_code one edge later, or causes a jump of more than one rung. A timer that fails to restart, or that expires early, shows up as two changes closer together than the dwell, so the spacing between steps is measured in whole cycles. A stuck preamble-lock or hold flag shows up as a frozen code when tracking should resume, which is visible at the first edge after rx_en returns or the hold bit clears.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  localparam int RUNGS    = 6;
  localparam int IDX_W    = 3;
  localparam int CODE_W   = 8;
  localparam int HOLD_BIT = 6;
  localparam int MAN_W    = 3;

  typedef enum logic [1:0] {
    LOCK_FREE     = 2'd0,
    LOCK_MANUAL   = 2'd1,
    LOCK_HOLD     = 2'd2,
    LOCK_PREAMBLE = 2'd3
  } lock_sel_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } step_dir_e;

  // rung index to gain status code, lowest gain first
  function automatic logic [CODE_W-1:0] rung_code(input logic [IDX_W-1:0] idx);
    logic [CODE_W-1:0] c;
    case (idx)
      3'd0:    c = 8'h00;
      3'd1:    c = 8'h01;
      3'd2:    c = 8'h02;
      3'd3:    c = 8'h0A;
      3'd4:    c = 8'h12;
      default: c = 8'h16;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rxg_dwell_timer.sv
module rxg_dwell_timer #(
  parameter int DIV_W    = 8,
  parameter int TICK_NUM = 4,
  parameter int TICK_DEN = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_i,
  output logic             expired_o
);

  localparam int ACC_W = $clog2(TICK_DEN + TICK_NUM) + 1;
  localparam logic [ACC_W-1:0] NUM_V = ACC_W'(TICK_NUM);
  localparam logic [ACC_W-1:0] DEN_V = ACC_W'(TICK_DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [DIV_W-1:0] cnt_q;

  assign acc_sum   = acc_q + NUM_V;
  assign expired_o = (cnt_q >= div_i);

  // fractional prescaler: NUM/DEN ticks per clock, preloaded with one step
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q <= NUM_V;
      cnt_q <= '0;
    end else if (!expired_o) begin
      if (acc_sum >= DEN_V) begin
        acc_q <= acc_sum - DEN_V;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

endmodule

// File: rtl/rxg_lock_policy.sv
module rxg_lock_policy
  import rxg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rx_en,
  input  logic      preamble_det,
  input  lock_sel_e lock_sel,
  input  logic      host_hold,
  output logic      auto_en,
  output logic      manual_en
);

  logic locked_q;
  logic pre_frozen;

  assign pre_frozen = locked_q || preamble_det;
  assign manual_en  = !host_hold && (lock_sel == LOCK_MANUAL);

  always_comb begin
    auto_en = 1'b0;
    if (!host_hold && rx_en) begin
      case (lock_sel)
        LOCK_FREE:     auto_en = 1'b1;
        LOCK_PREAMBLE: auto_en = !pre_frozen;
        default:       auto_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      locked_q <= 1'b0;
    end else if (lock_sel == LOCK_PREAMBLE && preamble_det) begin
      locked_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rxg_gain_ladder.sv
module rxg_gain_ladder
  import rxg_pkg::*;
#(
  parameter int RSSI_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expired,
  input  logic              auto_en,
  input  logic              manual_en,
  input  logic [MAN_W-1:0]  man_idx,
  input  logic [RSSI_W-1:0] rssi,
  input  logic [RSSI_W-1:0] thr_high,
  input  logic [RSSI_W-1:0] thr_low,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CODE_W-1:0] code_o,
  output logic              change_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RUNGS - 1);

  step_dir_e        dir;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] man_clamped;

  always_comb begin
    if (rssi > thr_high)     dir = DIR_DOWN;
    else if (rssi < thr_low) dir = DIR_UP;
    else                     dir = DIR_NONE;
  end

  assign man_clamped = (IDX_W'(man_idx) > TOP_IDX) ? TOP_IDX : IDX_W'(man_idx);

  always_comb begin
    idx_d = idx_q;
    if (manual_en) begin
      idx_d = man_clamped;
    end else if (auto_en && expired) begin
      if (dir == DIR_DOWN && idx_q != '0)         idx_d = idx_q - 1'b1;
      else if (dir == DIR_UP && idx_q != TOP_IDX) idx_d = idx_q + 1'b1;
    end
  end

  assign change_o = (idx_d != idx_q);
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= TOP_IDX;
      code_o <= rung_code(TOP_IDX);
    end else begin
      idx_q  <= idx_d;
      code_o <= rung_code(idx_d);
    end
  end

endmodule

// File: rtl/rx_gain_stepper.sv
module rx_gain_stepper
  import rxg_pkg::*;
#(
  parameter int RSSI_W   = 8,
  parameter int DIV_W    = 8,
  parameter int TICK_NUM = 4,
  parameter int TICK_DEN = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [RSSI_W-1:0] rssi,
  input  logic              preamble_det,
  input  logic [1:0]        lock_sel,
  input  logic [7:0]        host_mode,
  input  logic [RSSI_W-1:0] thr_high,
  input  logic [RSSI_W-1:0] thr_low,
  input  logic [DIV_W-1:0]  dwell_div,
  output logic [CODE_W-1:0] gain_code
);

  logic             expired;
  logic             auto_en;
  logic             manual_en;
  logic             gain_change;
  logic [IDX_W-1:0] gain_idx;
  logic             unused_mode_bits;

  assign unused_mode_bits = ^{host_mode[7], host_mode[5:MAN_W]};

  rxg_dwell_timer #(
    .DIV_W   (DIV_W),
    .TICK_NUM(TICK_NUM),
    .TICK_DEN(TICK_DEN)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (gain_change),
    .div_i    (dwell_div),
    .expired_o(expired)
  );

  rxg_lock_policy u_policy (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .preamble_det(preamble_det),
    .lock_sel    (lock_sel_e'(lock_sel)),
    .host_hold   (host_mode[HOLD_BIT]),
    .auto_en     (auto_en),
    .manual_en   (manual_en)
  );

  rxg_gain_ladder #(.RSSI_W(RSSI_W)) u_ladder (
    .clk      (clk),
    .rst      (rst),
    .expired  (expired),
    .auto_en  (auto_en),
    .manual_en(manual_en),
    .man_idx  (host_mode[MAN_W-1:0]),
    .rssi     (rssi),
    .thr_high (thr_high),
    .thr_low  (thr_low),
    .idx_o    (gain_idx),
    .code_o   (gain_code),
    .change_o (gain_change)
  );

endmodule

// File: rtl/rx_gain_stepper_chk.sv
module rx_gain_stepper_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             preamble_det,
  input logic [1:0]       lock_sel,
  input logic             host_hold,
  input logic [DIV_W-1:0] dwell_div,
  input logic [2:0]       gain_idx,
  input logic [7:0]       gain_code
);

  logic man_now;
  assign man_now = !host_hold && (lock_sel == 2'd1);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (gain_code == 8'h00 || gain_code == 8'h01 || gain_code == 8'h02 ||
     gain_code == 8'h0A || gain_code == 8'h12 || gain_code == 8'h16));

  assert_one_rung_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(man_now) && $changed(gain_idx)) |->
      (gain_idx == $past(gain_idx) + 3'd1 || gain_idx + 3'd1 == $past(gain_idx)));

  assert_dwell_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ($changed(gain_code) && dwell_div != '0 && !man_now) |=> $stable(gain_code));

  assert_host_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(host_hold)) |-> $stable(gain_code));

  assert_preamble_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (lock_sel == 2'd3 && !host_hold && rx_en && preamble_det) |=> $stable(gain_code));

  assert_rx_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rx_en) && !$past(man_now)) |-> $stable(gain_code));

endmodule

bind rx_gain_stepper rx_gain_stepper_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_en       (rx_en),
  .preamble_det(preamble_det),
  .lock_sel    (lock_sel),
  .host_hold   (host_mode[6]),
  .dwell_div   (dwell_div),
  .gain_idx    (gain_idx),
  .gain_code   (gain_code)
);

// File: tb/tb_rx_gain_stepper.sv
module tb_rx_gain_stepper;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_en;
  logic [7:0] rssi;
  logic       preamble_det;
  logic [1:0] lock_sel;
  logic [7:0] host_mode;
  logic [7:0] thr_high;
  logic [7:0] thr_low;
  logic [7:0] dwell_div;
  logic [7:0] gain_code;

  always #10 clk = ~clk;

  rx_gain_stepper dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rssi(rssi), .preamble_det(preamble_det),
    .lock_sel(lock_sel), .host_mode(host_mode), .thr_high(thr_high), .thr_low(thr_low),
    .dwell_div(dwell_div), .gain_code(gain_code)
  );

  typedef struct {
    string      req;
    logic [7:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_code(input string req, input logic [7:0] exp);
    sb_item_t it;
    it.req = req;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic check_num(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected codes and compares against the output
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (gain_code !== it.exp) begin
          errors++;
          $display("FAIL %s actual 0x%02h expected 0x%02h", it.req, gain_code, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      #1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] prev;
    rst = 1; rx_en = 1; rssi = 8'd150; preamble_det = 0; lock_sel = 2'd0;
    host_mode = 8'h00; thr_high = 8'd200; thr_low = 8'd100; dwell_div = 8'd1;
    tick(3);
    expect_code("R1 reset to top rung", 8'h16);
    rst = 0;
    tick(50);
    expect_code("R4 in-window no step", 8'h16);

    // R3 step down, R6 spacing for divide 1 is 32 cycles
    rssi = 8'd250;
    tick(1);
    expect_code("R3 step down one rung", 8'h12);
    tick(31);
    expect_code("R6 still dwelling", 8'h12);
    tick(1);
    expect_code("R6 step after 32 cycles", 8'h0A);
    tick(200);
    expect_code("R5 saturate at low end", 8'h00);

    // R4 step up, R5 saturate high
    rssi = 8'd10;
    tick(1);
    expect_code("R4 step up one rung", 8'h01);
    tick(300);
    expect_code("R5 saturate at high end", 8'h16);

    // R6 default divide: 1250 cycles between changes
    dwell_div = 8'h28; rssi = 8'd250;
    prev = gain_code; n = 0;
    while (gain_code == prev && n < 3000) begin tick(1); n++; end
    prev = gain_code; n = 0;
    while (gain_code == prev && n < 3000) begin tick(1); n++; end
    check_num("R6 dwell 0x28 cycles", n, 1250);
    expect_code("R7 free running second step", 8'h0A);

    // R6 divide zero: step each cycle
    dwell_div = 8'd0; rssi = 8'd10;
    tick(1);
    expect_code("R6 zero divide first", 8'h12);
    tick(1);
    expect_code("R6 zero divide second", 8'h16);

    // R9 host hold override
    host_mode = 8'h40; rssi = 8'd250;
    tick(20);
    expect_code("R9 host hold freezes", 8'h16);
    host_mode = 8'h00;
    tick(1);
    expect_code("R9 resume after clear", 8'h12);

    // R7 lock_sel 2 holds
    lock_sel = 2'd2;
    tick(20);
    expect_code("R7 hold mode high rssi", 8'h12);
    rssi = 8'd10;
    tick(20);
    expect_code("R7 hold mode low rssi", 8'h12);

    // R8 manual
    lock_sel = 2'd1; host_mode = 8'h02;
    tick(1);
    expect_code("R8 manual index 2", 8'h02);
    host_mode = 8'h07;
    tick(1);
    expect_code("R8 manual clamp", 8'h16);
    host_mode = 8'h03;
    tick(1);
    expect_code("R8 manual index 3", 8'h0A);
    host_mode = 8'h00;
    tick(20);
    expect_code("R8 manual ignores thresholds", 8'h00);
    host_mode = 8'h43;
    tick(5);
    expect_code("R9 hold beats manual", 8'h00);

    // R10 preamble lock
    host_mode = 8'h00; lock_sel = 2'd3;
    tick(1);
    expect_code("R10 tracking before preamble", 8'h01);
    tick(1);
    expect_code("R10 tracking before preamble 2", 8'h02);
    preamble_det = 1;
    tick(1);
    preamble_det = 0;
    expect_code("R10 freeze on pulse cycle", 8'h02);
    tick(20);
    expect_code("R10 stays frozen", 8'h02);
    rx_en = 0;
    tick(1);
    expect_code("R11 rx low no step", 8'h02);
    rx_en = 1;
    tick(1);
    expect_code("R11 lock released", 8'h0A);

    // R11 rx_en low in free running
    rx_en = 0; lock_sel = 2'd0;
    tick(20);
    expect_code("R11 rx low free mode", 8'h0A);

    // R12 conflicting thresholds
    rx_en = 1; thr_high = 8'd50; thr_low = 8'd100; rssi = 8'd70;
    tick(1);
    expect_code("R12 down wins", 8'h02);
    thr_high = 8'd200; thr_low = 8'd100; rssi = 8'd200;
    tick(20);
    expect_code("R3 equal to high no step", 8'h02);
    rssi = 8'd100;
    tick(20);
    expect_code("R4 equal to low no step", 8'h02);

    // R1 reset restarts dwell
    dwell_div = 8'd1; rssi = 8'd250; rst = 1;
    tick(3);
    expect_code("R1 reset mid run", 8'h16);
    rst = 0;
    tick(31);
    expect_code("R1 dwell cleared by reset", 8'h16);
    tick(1);
    expect_code("R1 first step after reset", 8'h12);

    tick(2);
    wait (sb_q.size() == 0);
    finish_run();
  end

endmodule